// File: doc/BRIEF.md
# Strobed Byte Write Engine

This block moves a single byte from the head of an on-chip FIFO to an external 8-bit asynchronous peripheral each time it is started. A controller outside the block decides when a transfer should happen and pulses `start`. The engine accepts that pulse only when it is idle and the FIFO holds data. It then waits for as long as the peripheral reports that it is full. Once the peripheral has room, the engine drives the head byte onto the data port with the output enable raised and pulls the active-low write strobe low for a fixed number of interface-clock cycles.

After the strobe is released, the engine pops the FIFO with a one-cycle pulse. It keeps the strobe high for a fixed recovery tail, returns to idle and flags completion. The engine has no abort path: a peripheral that stays full stalls the engine in its waiting state. Every output comes straight from a flip-flop, so the strobe and data lines do not glitch.

Top module: `strobe_wr_engine`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `wr_n` is 1, `data_oe` is 0, `data_out` is 0, and `pop`, `busy` and `done` are 0.
- R2: A `start` sampled high is accepted only while the engine is idle and `fifo_empty` is 0. When accepted, `busy` is 1 in the next cycle. A `start` seen while `fifo_empty` is 1 leaves `busy`, `wr_n` and `pop` unchanged.
- R3: After acceptance, the engine waits while `periph_ready` is 0 (peripheral full). For as long as it waits, `wr_n` stays 1, `data_oe` stays 0 and `busy` stays 1, with no time limit.
- R4: The first clock edge that samples `periph_ready` as 1 during the wait makes `wr_n` 0 for exactly STROBE_CYC consecutive cycles (default 3).
- R5: `data_oe` is 1 exactly in the cycles where `wr_n` is 0. In those cycles `data_out` equals the FIFO head byte captured as the strobe begins. In every other cycle `data_out` is 0.
- R6: `pop` is 1 for exactly one cycle per transfer: the first cycle after the strobe returns to 1.
- R7: After the strobe, `wr_n` stays 1 for RECOV_CYC cycles (default 2), the first of which carries `pop`. Only then does `busy` fall. A `start` that arrives while `busy` is 1 is ignored and does not cause a second pop.
- R8: `done` is 1 for exactly one cycle, the first cycle in which `busy` is 0 again after a transfer.
- R9: `periph_ready` is sampled only in the waiting state. If it drops during the strobe or the recovery tail, the strobe length and the pop are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one transfer |
| fifo_empty | input | 1 | 1 when the interface FIFO holds no byte |
| fifo_head | input | DATA_W | Byte at the FIFO head |
| periph_ready | input | 1 | 1 when the peripheral is not full |
| pop | output | 1 | One-cycle FIFO read-pointer advance |
| wr_n | output | 1 | Active-low write strobe to the peripheral |
| data_out | output | DATA_W | Byte driven to the peripheral data port |
| data_oe | output | 1 | Data port output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion flag |

## Verification
The assertions assume that `fifo_head` stays stable from the accepted start until the pop, which is what a FIFO that only changes on `pop` provides. They also assume that `rst` is high at time zero. The bench therefore changes the head byte only between transfers and holds reset for several cycles at the start. The peripheral ready input is left unconstrained. The stimulus deliberately holds it low for long stretches, and in some transfers drops it in the middle of a strobe, so that the no-abort stall and the single sampling point are both exercised.

// File: rtl/swe_pkg.sv
package swe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_STROBE = 2'd2,
    ST_RECOV  = 2'd3
  } swe_state_e;
endpackage

// File: rtl/swe_seq.sv
// Sequencer: idle -> wait-for-room -> strobe -> recovery -> idle.
module swe_seq
  import swe_pkg::*;
#(
  parameter int STROBE_CYC = 3,
  parameter int RECOV_CYC  = 2,
  parameter int CNT_W      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       fifo_empty,
  input  logic       periph_ready,
  output swe_state_e state_d,
  output logic       enter_strobe,
  output logic       pop_d,
  output logic       done_d
);
  localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] RECOV_LAST  = CNT_W'(RECOV_CYC - 1);

  swe_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start && !fifo_empty) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end
      end
      ST_WAIT: begin
        if (periph_ready) begin
          state_d = ST_STROBE;
          cnt_d   = '0;
        end
      end
      ST_STROBE: begin
        if (cnt_q == STROBE_LAST) begin
          state_d = ST_RECOV;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt_q == RECOV_LAST) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  assign enter_strobe = (state_q != ST_STROBE) && (state_d == ST_STROBE);
  assign pop_d        = (state_q == ST_STROBE) && (state_d == ST_RECOV);
  assign done_d       = (state_q == ST_RECOV)  && (state_d == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/swe_outreg.sv
// Output stage: every pin leaves from a flop, decoded from the next state.
module swe_outreg
  import swe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  swe_state_e        state_d,
  input  logic              enter_strobe,
  input  logic              pop_d,
  input  logic              done_d,
  input  logic [DATA_W-1:0] fifo_head,
  output logic              wr_n,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              pop,
  output logic              busy,
  output logic              done
);
  logic strobe_d;
  assign strobe_d = (state_d == ST_STROBE);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_n     <= 1'b1;
      data_oe  <= 1'b0;
      data_out <= '0;
      pop      <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      wr_n    <= !strobe_d;
      data_oe <= strobe_d;
      if (!strobe_d)
        data_out <= '0;
      else if (enter_strobe)
        data_out <= fifo_head;
      pop  <= pop_d;
      busy <= (state_d != ST_IDLE);
      done <= done_d;
    end
  end
endmodule

// File: rtl/strobe_wr_engine.sv
module strobe_wr_engine
  import swe_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 3,
  parameter int RECOV_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_head,
  input  logic              periph_ready,
  output logic              pop,
  output logic              wr_n,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              busy,
  output logic              done
);
  localparam int MAX_CYC = (STROBE_CYC > RECOV_CYC) ? STROBE_CYC : RECOV_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  swe_state_e state_d;
  logic       enter_strobe, pop_d, done_d;

  swe_seq #(
    .STROBE_CYC(STROBE_CYC),
    .RECOV_CYC (RECOV_CYC),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .fifo_empty  (fifo_empty),
    .periph_ready(periph_ready),
    .state_d     (state_d),
    .enter_strobe(enter_strobe),
    .pop_d       (pop_d),
    .done_d      (done_d)
  );

  swe_outreg #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .state_d     (state_d),
    .enter_strobe(enter_strobe),
    .pop_d       (pop_d),
    .done_d      (done_d),
    .fifo_head   (fifo_head),
    .wr_n        (wr_n),
    .data_out    (data_out),
    .data_oe     (data_oe),
    .pop         (pop),
    .busy        (busy),
    .done        (done)
  );
endmodule

// File: rtl/strobe_wr_engine_chk.sv
module strobe_wr_engine_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              fifo_empty,
  input logic              pop,
  input logic              wr_n,
  input logic [DATA_W-1:0] data_out,
  input logic              data_oe,
  input logic              busy,
  input logic              done
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (wr_n && !data_oe && data_out == '0 && !pop && !busy && !done));

  a_r2_empty_rejected: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done && start && fifo_empty) |=> !busy);

  a_r5_oe_matches_strobe: assert property (@(posedge clk) disable iff (rst)
    data_oe == !wr_n);

  a_r5_bus_zero_when_off: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data_out == '0));

  a_r5_data_held: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !$past(wr_n)) |-> $stable(data_out));

  a_r6_pop_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pop |=> !pop);

  a_r6_pop_after_strobe: assert property (@(posedge clk) disable iff (rst)
    pop |-> (wr_n && !$past(wr_n) && busy));

  a_r7_strobe_within_busy: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> busy);

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

bind strobe_wr_engine strobe_wr_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .fifo_empty(fifo_empty),
  .pop       (pop),
  .wr_n      (wr_n),
  .data_out  (data_out),
  .data_oe   (data_oe),
  .busy      (busy),
  .done      (done)
);

// File: tb/tb_strobe_wr_engine.sv
`timescale 1ns/1ps
module tb_strobe_wr_engine;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              fifo_empty = 1'b1;
  logic [DATA_W-1:0] fifo_head = '0;
  logic              periph_ready = 1'b0;
  logic              pop, wr_n, data_oe, busy, done;
  logic [DATA_W-1:0] data_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  strobe_wr_engine #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .start(start), .fifo_empty(fifo_empty),
    .fifo_head(fifo_head), .periph_ready(periph_ready), .pop(pop),
    .wr_n(wr_n), .data_out(data_out), .data_oe(data_oe),
    .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // R1: reset values of every output
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    check("R1", "wr_n",     wr_n, 1);
    check("R1", "data_oe",  data_oe, 0);
    check("R1", "data_out", data_out, 0);
    check("R1", "pop",      pop, 0);
    check("R1", "busy",     busy, 0);
    check("R1", "done",     done, 0);
    rst = 1'b0;
    tick();
    check("R1", "busy after release", busy, 0);
    check("R1", "wr_n after release", wr_n, 1);
  endtask

  // R2: start while the FIFO is empty is ignored
  task automatic t_empty_ignored();
    fifo_empty   = 1'b1;
    periph_ready = 1'b1;
    start        = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R2", "busy with empty fifo", busy, 0);
      check("R2", "wr_n with empty fifo", wr_n, 1);
      check("R2", "pop with empty fifo",  pop, 0);
    end
    start = 1'b0;
    tick();
  endtask

  // One transfer: wait_cyc cycles of full, then strobe, pop, recovery, done.
  task automatic run_txn(input logic [DATA_W-1:0] head, input int wait_cyc,
                         input bit hold_start, input bit drop_ready);
    fifo_empty   = 1'b0;
    fifo_head    = head;
    periph_ready = (wait_cyc == 0);
    start        = 1'b1;
    tick();
    if (!hold_start) start = 1'b0;
    check("R2", "busy after start", busy, 1);
    check("R3", "wr_n while waiting", wr_n, 1);
    for (int i = 0; i < wait_cyc; i++) begin
      tick();
      check("R3", "wr_n held high while full", wr_n, 1);
      check("R3", "oe low while full", data_oe, 0);
      check("R3", "busy while full", busy, 1);
    end
    periph_ready = 1'b1;
    for (int s = 0; s < 3; s++) begin
      tick();
      if (drop_ready && s == 0) periph_ready = 1'b0;
      check(drop_ready ? "R9" : "R4", "wr_n asserted", wr_n, 0);
      check("R5", "data_oe in strobe", data_oe, 1);
      check("R5", "data_out in strobe", data_out, head);
      check("R6", "no pop during strobe", pop, 0);
    end
    tick();
    check("R6", "pop after strobe", pop, 1);
    check("R7", "wr_n released", wr_n, 1);
    check("R5", "bus cleared", data_out, 0);
    check("R5", "oe cleared", data_oe, 0);
    check("R7", "busy in recovery 1", busy, 1);
    tick();
    check("R6", "pop single cycle", pop, 0);
    check("R7", "wr_n recovery 2", wr_n, 1);
    check("R7", "busy in recovery 2", busy, 1);
    start = 1'b0;
    fifo_empty = 1'b1;
    tick();
    check("R7", "busy falls after recovery", busy, 0);
    check("R8", "done pulse", done, 1);
    check("R7", "no second pop", pop, 0);
    tick();
    check("R8", "done single cycle", done, 0);
    check("R7", "still idle", busy, 0);
  endtask

  task automatic t_ready_at_once();  run_txn(8'hA5, 0, 1'b0, 1'b0); endtask
  task automatic t_long_stall();     run_txn(8'h3C, 25, 1'b0, 1'b0); endtask
  task automatic t_start_held();     run_txn(8'hFF, 2, 1'b1, 1'b0); endtask
  task automatic t_ready_drop();     run_txn(8'h01, 1, 1'b0, 1'b1); endtask

  initial begin
    t_reset();
    t_empty_ignored();
    t_ready_at_once();
    t_long_stall();
    t_start_held();
    t_ready_drop();
    t_empty_ignored();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule